// File: doc/BRIEF.md
# Printer Port Register Block

This block is a byte-wide register front end for a PC-style printer port. A host reads and writes a data byte, a status byte and a control byte over a simple register bus. The block also holds a small model of the printer side of the strobe/busy/acknowledge handshake, so a driver can push bytes with no real printer attached. Each byte the host strobes out appears for one clock on a byte output with a valid flag. A level interrupt tells the host that the printer acknowledged.

The bus offset is the address taken modulo 8, so the register window repeats across the address space. Reads are combinational on the cycle the read enable is high. Any side effect of an access (status toggling, interrupt clear, byte emission) lands on the clock edge that ends that cycle. An input byte latch, loaded from an external port while the direction bit selects input, supplies the data read in input mode.

Top module: `prn_port`

## Requirements
- R1: Only address bits 2:0 are decoded: offset 0 is data, 1 is status, 2 is control. A read of offsets 3 to 7 returns 0xFF, and writes to offsets 3 to 7 change nothing.
- R2: After reset the data byte and the input latch are 0xFF, status reads 0xD9, control reads 0xCC, and irq and out_valid are 0.
- R3: A control write stores the written byte with bits 7:6 forced to 1, and a control read returns the stored byte. Control bits: 5 direction (1 = input), 4 interrupt enable, 3 select, 2 init, 1 auto-linefeed, 0 strobe.
- R4: A control write whose init bit (bit 2) is 0 loads status with 0xD8.
- R5: A control write with init, select and strobe all 1 clears status bit 7 (busy, inverted sense) and leaves the other status bits alone.
- R6: When such a write finds the stored strobe bit at 0, out_valid is 1 in the next cycle only, with out_byte equal to the stored data byte.
- R7: A control write with init 1, select 1 and strobe 0 sets irq from the next cycle, but only when the control value stored before the write had interrupt enable (bit 4) set.
- R8: A status read clears irq from the next cycle.
- R9: A status read returns the current status. After it, when status bit 7 is 0 and stored strobe is 0, status bit 6 (acknowledge) is cleared if it was 1; otherwise bits 7 and 6 are both set.
- R10: A data read returns the input latch when control bit 5 is 1 and the last written data byte otherwise. The latch loads in_byte on a clock with in_load high while bit 5 is 1.
- R11: A write to the status offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register address, decoded modulo 8 |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle (ignored while bus_wr is high) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the address on the bus |
| in_byte | input | 8 | Byte presented by the far side in input mode |
| in_load | input | 1 | Loads in_byte into the input latch when direction is input |
| out_byte | output | 8 | Byte strobed out by the host |
| out_valid | output | 1 | One-cycle flag qualifying out_byte |
| irq | output | 1 | Level interrupt request |

## Verification
The bench goes after the edge-sensitive strobe: a design that emitted on the strobe level rather than on its 0-to-1 change would repeat bytes when the host rewrites control with strobe still 1. It checks that the interrupt enable is taken from the control value before the write, since a design using the new value would raise or miss interrupts on the same write that toggles enable. Repeated status reads walk the acknowledge/busy toggle, and a design that tested the new strobe bit or dropped the busy condition would show the wrong sequence. Aliased offsets, status writes and latch loads in output mode confirm that nothing moves when it should not.

// File: rtl/prn_pkg.sv
package prn_pkg;
  localparam int OFS_W = 3;
  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
  localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;

  localparam int ST_BUSY_N = 7;
  localparam int ST_ACK    = 6;

  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_STB  = 0;

  localparam logic [7:0] CTRL_FIXED  = 8'hC0;
  localparam logic [7:0] RST_DATA    = 8'hFF;
  localparam logic [7:0] RST_STAT    = 8'hD9;
  localparam logic [7:0] RST_CTRL    = 8'hCC;
  localparam logic [7:0] INIT_STAT   = 8'hD8;
  localparam logic [7:0] HOLE_READ   = 8'hFF;

  typedef struct packed {
    logic data_wr;
    logic ctrl_wr;
    logic stat_rd;
  } acc_t;

  function automatic logic [7:0] ctrl_store(input logic [7:0] v);
    return v | CTRL_FIXED;
  endfunction

  function automatic logic [7:0] stat_on_ctrl(input logic [7:0] st,
                                              input logic v_init,
                                              input logic v_sel,
                                              input logic v_stb);
    logic [7:0] r;
    r = st;
    if (!v_init) r = INIT_STAT;
    else if (v_sel && v_stb) r[ST_BUSY_N] = 1'b0;
    return r;
  endfunction

  function automatic logic [7:0] stat_on_read(input logic [7:0] st,
                                              input logic cur_stb);
    logic [7:0] r;
    r = st;
    if (!st[ST_BUSY_N] && !cur_stb) begin
      if (st[ST_ACK]) r[ST_ACK] = 1'b0;
      else begin
        r[ST_ACK]    = 1'b1;
        r[ST_BUSY_N] = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/prn_ctrl_reg.sv
module prn_ctrl_reg
  import prn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_wr,
  input  logic       ctrl_wr,
  input  logic [7:0] wr_data,
  input  logic [7:0] in_byte,
  input  logic       in_load,
  output logic [7:0] ctrl_q,
  output logic [7:0] dout_q,
  output logic [7:0] din_q,
  output logic [7:0] out_byte,
  output logic       out_valid
);
  logic [7:0] ctrl_nx;
  logic       emit_ev;

  assign ctrl_nx = ctrl_store(wr_data);
  assign emit_ev = ctrl_wr && ctrl_nx[CT_INIT] && ctrl_nx[CT_SEL] &&
                   ctrl_nx[CT_STB] && !ctrl_q[CT_STB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= RST_CTRL;
      dout_q    <= RST_DATA;
      din_q     <= RST_DATA;
      out_byte  <= RST_DATA;
      out_valid <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_nx;
      if (data_wr) dout_q <= wr_data;
      if (in_load && ctrl_q[CT_DIR]) din_q <= in_byte;
      out_valid <= emit_ev;
      if (emit_ev) out_byte <= dout_q;
    end
  end

  // R3
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_q == ($past(wr_data) | 8'hC0));
  // R6
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R6
  out_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(ctrl_wr) && !$past(ctrl_q[CT_STB]));
  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CT_DIR] |=> $stable(din_q));
endmodule

// File: rtl/prn_status_reg.sv
module prn_status_reg
  import prn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       v_init,
  input  logic       v_sel,
  input  logic       v_stb,
  input  logic       stat_rd,
  input  logic       cur_stb,
  output logic [7:0] status_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status_q <= RST_STAT;
    else if (ctrl_wr) status_q <= stat_on_ctrl(status_q, v_init, v_sel, v_stb);
    else if (stat_rd) status_q <= stat_on_read(status_q, cur_stb);
  end

  // R4
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !v_init |=> status_q == 8'hD8);
  // R11
  stat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr && !stat_rd |=> $stable(status_q));
  // R9
  stat_busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && (status_q[ST_BUSY_N] || cur_stb) |=> $stable(status_q));
endmodule

// File: rtl/prn_irq_unit.sv
module prn_irq_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic v_init,
  input  logic v_sel,
  input  logic v_stb,
  input  logic old_ien,
  input  logic stat_rd,
  output logic irq
);
  logic set_ev;

  assign set_ev = ctrl_wr && v_init && v_sel && !v_stb && old_ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (set_ev)  irq <= 1'b1;
    else if (stat_rd) irq <= 1'b0;
  end

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !irq);
  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctrl_wr) && $past(old_ien));
endmodule

// File: rtl/prn_port.sv
module prn_port
  import prn_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        in_byte,
  input  logic              in_load,
  output logic [7:0]        out_byte,
  output logic              out_valid,
  output logic              irq
);
  logic [OFS_W-1:0] ofs;
  acc_t             acc;
  logic [7:0]       ctrl_q, dout_q, din_q, status_q;
  logic             unused_addr_hi;

  assign ofs = bus_addr[OFS_W-1:0];
  generate
    if (ADDR_W > OFS_W) begin : g_hi
      assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFS_W];
    end else begin : g_nohi
      assign unused_addr_hi = 1'b0;
    end
  endgenerate

  assign acc.data_wr = bus_wr && (ofs == OFS_DATA);
  assign acc.ctrl_wr = bus_wr && (ofs == OFS_CTRL);
  assign acc.stat_rd = bus_rd && !bus_wr && (ofs == OFS_STAT);

  prn_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .data_wr(acc.data_wr), .ctrl_wr(acc.ctrl_wr), .wr_data(bus_wdata),
    .in_byte(in_byte), .in_load(in_load),
    .ctrl_q(ctrl_q), .dout_q(dout_q), .din_q(din_q),
    .out_byte(out_byte), .out_valid(out_valid)
  );

  prn_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(acc.ctrl_wr),
    .v_init(bus_wdata[CT_INIT]), .v_sel(bus_wdata[CT_SEL]),
    .v_stb(bus_wdata[CT_STB]), .stat_rd(acc.stat_rd),
    .cur_stb(ctrl_q[CT_STB]), .status_q(status_q)
  );

  prn_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(acc.ctrl_wr),
    .v_init(bus_wdata[CT_INIT]), .v_sel(bus_wdata[CT_SEL]),
    .v_stb(bus_wdata[CT_STB]), .old_ien(ctrl_q[CT_IEN]),
    .stat_rd(acc.stat_rd), .irq(irq)
  );

  always_comb begin
    case (ofs)
      OFS_DATA: bus_rdata = ctrl_q[CT_DIR] ? din_q : dout_q;
      OFS_STAT: bus_rdata = status_q;
      OFS_CTRL: bus_rdata = ctrl_q;
      default:  bus_rdata = HOLE_READ;
    endcase
  end

  // R1
  hole_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (ofs > OFS_CTRL) |=> $stable(ctrl_q) && $stable(dout_q) && $stable(status_q));
  // R3
  ctrl_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (ofs == OFS_CTRL) |-> bus_rdata[7:6] == 2'b11);
endmodule

// File: tb/test_prn_port.sv
module test_prn_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] in_byte = '0;
  logic       in_load = 1'b0;
  logic [7:0] out_byte;
  logic       out_valid;
  logic       irq;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] m_data, m_latch, m_stat, m_ctrl, m_emit_byte;
  bit         m_pend, m_emit;

  always #5 clk = ~clk;

  prn_port #(.ADDR_W(8)) i_prn_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_byte(in_byte), .in_load(in_load), .out_byte(out_byte),
    .out_valid(out_valid), .irq(irq)
  );

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] o);
    if (o == 3'd0) return m_ctrl[5] ? m_latch : m_data;
    if (o == 3'd1) return m_stat;
    if (o == 3'd2) return m_ctrl;
    return 8'hFF;
  endfunction

  // Bench's own restatement of the write effects
  task automatic model_write(input logic [2:0] o, input logic [7:0] v);
    logic [7:0] nv;
    if (o == 3'd0) m_data = v;
    else if (o == 3'd2) begin
      nv = {2'b11, v[5:0]};
      if (nv[2] == 1'b0) m_stat = 8'b1101_1000;
      else if (nv[3] && nv[0]) begin
        m_stat = m_stat & 8'h7F;
        if (m_ctrl[0] == 1'b0) begin m_emit = 1; m_emit_byte = m_data; end
      end else if (nv[3] && m_ctrl[4]) m_pend = 1;
      m_ctrl = nv;
    end
  endtask

  task automatic model_read(input logic [2:0] o);
    if (o == 3'd1) begin
      m_pend = 0;
      if ({m_stat[7], m_ctrl[0]} == 2'b00)
        m_stat[7:6] = m_stat[6] ? 2'b00 : 2'b11;
    end
  endtask

  // Starts and ends at a falling edge
  task automatic access(input bit wr, input logic [7:0] a, input logic [7:0] v,
                        input string req);
    logic [2:0] o;
    o = a[2:0];
    bus_addr = a; bus_wr = wr; bus_rd = !wr; bus_wdata = v;
    #1;
    if (!wr) chk8(req, bus_rdata, exp_read(o));
    @(posedge clk);
    m_emit = 0;
    if (wr) model_write(o, v); else model_read(o);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    chk1("R7/R8 irq level", irq, m_pend);
    chk1("R6 out_valid", out_valid, m_emit);
    if (m_emit) chk8("R6 out_byte", out_byte, m_emit_byte);
  endtask

  task automatic load_in(input logic [7:0] v);
    in_byte = v; in_load = 1;
    @(posedge clk);
    if (m_ctrl[5]) m_latch = v;
    @(negedge clk);
    in_load = 0;
  endtask

  function automatic string rd_req(input logic [2:0] o);
    case (o)
      3'd0: return "R10 data read";
      3'd1: return "R9 status read";
      3'd2: return "R3 control read";
      default: return "R1 hole read";
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0303));
    m_data = 8'hFF; m_latch = 8'hFF; m_stat = 8'hD9; m_ctrl = 8'hCC;
    m_pend = 0; m_emit = 0; m_emit_byte = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset values
    chk1("R2 irq", irq, 1'b0);
    chk1("R2 out_valid", out_valid, 1'b0);
    access(0, 8'h00, 0, "R2 data");
    access(0, 8'h02, 0, "R2 control");
    access(0, 8'h01, 0, "R2 status");
    access(0, 8'h0D, 0, "R1 hole read");
    // R1 aliasing and writes to holes
    access(1, 8'h48, 8'h3C, "");
    access(1, 8'hFB, 8'h00, "");
    access(0, 8'hA2, 0, "R1 alias control");
    access(0, 8'h08, 0, "R1 alias data");
    // R11 status write ignored
    access(1, 8'h01, 8'h00, "");
    access(0, 8'h01, 0, "R11 status after write");
    // R4 init low
    access(1, 8'h02, 8'h00, "");
    access(0, 8'h01, 0, "R4 status after init");
    // R5/R6 strobe sequence: data, strobe low, strobe high, strobe high again
    access(1, 8'h00, 8'hA5, "");
    access(1, 8'h02, 8'h1C, "");
    access(1, 8'h02, 8'h1D, "");
    access(0, 8'h01, 0, "R5 busy cleared");
    access(1, 8'h02, 8'h1D, "");
    // R9 toggle walk
    access(1, 8'h02, 8'h0C, "");
    access(1, 8'h02, 8'h0D, "");
    access(1, 8'h02, 8'h0C, "");
    repeat (4) access(0, 8'h01, 0, "R9 toggle walk");
    // R7 enable taken from old value
    access(1, 8'h02, 8'h1C, "");
    access(1, 8'h02, 8'h0C, "");
    access(1, 8'h02, 8'h0C, "");
    access(1, 8'h02, 8'h1C, "");
    access(0, 8'h01, 0, "R8 status read clears");
    // R10 direction and latch
    load_in(8'h5A);
    access(0, 8'h00, 0, "R10 latch ignored in output mode");
    access(1, 8'h02, 8'h2C, "");
    load_in(8'h96);
    access(0, 8'h00, 0, "R10 latch in input mode");
    access(1, 8'h02, 8'h0C, "");
    access(0, 8'h00, 0, "R10 back to output");
    // Random phase
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] a, v;
      op = $urandom_range(0, 9);
      a = $urandom;
      v = $urandom;
      if (op < 4) begin
        a[2:0] = 3'd2;
        if ($urandom_range(0, 2) != 0) v[3:2] = 2'b11;
        access(1, a, v, "");
      end else if (op == 4) begin
        access(1, a, v, "");
      end else if (op < 8) begin
        if (op < 7) a[2:0] = 3'd1;
        access(0, a, 0, rd_req(a[2:0]));
      end else if (op == 8) begin
        load_in(v);
      end else begin
        access(0, a, 0, rd_req(a[2:0]));
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule